// File: doc/BRIEF.md
# Sequential Byte Multiply-Divide Unit

This block multiplies or divides two unsigned 8-bit operands over several clock cycles. The two operands are the accumulator value (A) and the auxiliary register value (B). Both results go back to the same pair of registers. A multiply leaves the 16-bit product split across them, low byte in A and high byte in B. A divide leaves the quotient in A and the remainder in B. The unit also produces the carry and overflow flags, and each operation sets them by its own fixed rule.

The host gives a one-cycle start pulse together with an operation select and both operands. The unit then runs one bit per cycle for eight cycles. Multiply uses shift-and-add and divide uses the restoring method. Busy is high during that time. Done pulses for one cycle when the new A, B, carry and overflow values appear. The result outputs hold their values until the next operation completes.

Top module: `byte_muldiv`

## Requirements
- R1: During and after synchronous reset, busy, done, a_out, b_out, cy and ov are all 0 until an operation completes.
- R2: A start pulse while busy is 0 captures op_div (0 = multiply, 1 = divide), a_in and b_in. Busy reads 1 in the next cycle. Input values after that edge do not affect the result.
- R3: After the accepting edge, busy stays high for exactly 8 cycles. Done is then 1 for exactly one cycle, in the cycle right after the last busy cycle, and busy is 0 in that cycle.
- R4: A multiply gives a_out = low byte and b_out = high byte of the unsigned product a_in*b_in.
- R5: A multiply always gives cy = 0.
- R6: A multiply gives ov = 1 when the product is greater than 255, and ov = 0 otherwise.
- R7: A divide with b_in not 0 gives a_out = unsigned quotient and b_out = remainder of a_in/b_in.
- R8: A divide with b_in not 0 clears both cy and ov.
- R9: A divide with b_in = 0 sets ov = 1 and clears cy. a_out and b_out then equal the captured a_in and b_in. It keeps the same 8-cycle timing.
- R10: A start pulse while busy is 1 is ignored. The running operation's result and its done timing do not change.
- R11: a_out, b_out, cy and ov change only in a done cycle. They hold steady while busy is high and between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation request pulse |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | 8 | Operand A (multiplicand or dividend) |
| b_in | input | 8 | Operand B (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | Product low byte or quotient |
| b_out | output | 8 | Product high byte or remainder |
| cy | output | 1 | Carry flag result |
| ov | output | 1 | Overflow flag result |

## Verification
The bench targets the overflow edge of multiply. It compares 15*17 = 255 with 16*16 = 256. A design that tested the wrong product byte, or used a greater-or-equal limit, would report the wrong ov on one of these. It runs divides whose quotient is 0, whose divisor is 1, and whose dividend is 255. An off-by-one in the restoring step or in the number of iterations would show up as a wrong quotient or remainder in these cases. It divides by zero right after an overflowing multiply. This checks that ov is forced to 1 and that the operands come back unchanged, rather than the all-ones quotient the bare algorithm produces. It then follows with a normal divide, which catches an ov that sticks from earlier. Last, it pulses start again partway through an operation with different operands. A design that re-armed the operation would finish late or return the second pair's result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Operand width and derived iteration counter width
    localparam int unsigned MDU_W  = 8;
    localparam int unsigned MDU_CW = $clog2(MDU_W + 1);

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mdu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdu_state_e;

    // Working registers: hi = partial product or partial remainder,
    // lo = multiplier bits being consumed or quotient bits being built.
    typedef struct packed {
        mdu_op_e          op;
        logic [MDU_W-1:0] hi;
        logic [MDU_W-1:0] lo;
        logic [MDU_W-1:0] dvs;
        logic [MDU_W-1:0] a0;
        logic [MDU_W-1:0] b0;
    } mdu_work_t;

    // One shift-and-add step: add the multiplicand when the current
    // multiplier bit is set, then shift the double-width pair right.
    function automatic logic [2*MDU_W-1:0] mul_step(
        input logic [MDU_W-1:0] hi,
        input logic [MDU_W-1:0] lo,
        input logic [MDU_W-1:0] mcand
    );
        logic [MDU_W:0] sum;
        sum = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
        return {sum, lo[MDU_W-1:1]};
    endfunction

    // One restoring-division step: bring in the next dividend bit,
    // subtract when the divisor fits, record the quotient bit.
    function automatic logic [2*MDU_W-1:0] div_step(
        input logic [MDU_W-1:0] rem,
        input logic [MDU_W-1:0] quo,
        input logic [MDU_W-1:0] dvs
    );
        logic [MDU_W:0]   sh;
        logic             fits;
        logic [MDU_W-1:0] diff;
        sh   = {rem, quo[MDU_W-1]};
        fits = (sh >= {1'b0, dvs});
        diff = sh[MDU_W-1:0] - dvs;
        return {(fits ? diff : sh[MDU_W-1:0]), quo[MDU_W-2:0], fits};
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic step,
    output logic finish,
    output logic busy
);

    localparam logic [MDU_CW-1:0] LAST = MDU_CW'(MDU_W - 1);

    mdu_state_e        state;
    logic [MDU_CW-1:0] iter;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        iter  <= '0;
                    end
                end
                ST_RUN: begin
                    iter <= iter + 1'b1;
                    if (iter == LAST) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (state == ST_RUN);
        accept = (state == ST_IDLE) && start;
        step   = busy;
        finish = busy && (iter == LAST);
    end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
    import mdu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             step,
    input  logic             op_div,
    input  logic [MDU_W-1:0] a_in,
    input  logic [MDU_W-1:0] b_in,
    output mdu_work_t        work_nxt
);

    mdu_work_t work;
    logic [2*MDU_W-1:0] stepped;

    always_comb begin
        if (work.op == OP_DIV) begin
            stepped = div_step(work.hi, work.lo, work.dvs);
        end else begin
            stepped = mul_step(work.hi, work.lo, work.dvs);
        end
        work_nxt    = work;
        work_nxt.hi = stepped[2*MDU_W-1:MDU_W];
        work_nxt.lo = stepped[MDU_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
        end else if (accept) begin
            work.op  <= op_div ? OP_DIV : OP_MUL;
            work.hi  <= '0;
            work.lo  <= a_in;
            work.dvs <= b_in;
            work.a0  <= a_in;
            work.b0  <= b_in;
        end else if (step) begin
            work <= work_nxt;
        end
    end

endmodule

// File: rtl/byte_muldiv.sv
module byte_muldiv
    import mdu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_div,
    input  logic [MDU_W-1:0] a_in,
    input  logic [MDU_W-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [MDU_W-1:0] a_out,
    output logic [MDU_W-1:0] b_out,
    output logic             cy,
    output logic             ov
);

    logic      accept;
    logic      step;
    logic      finish;
    mdu_work_t work_nxt;

    mdu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .step   (step),
        .finish (finish),
        .busy   (busy)
    );

    mdu_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .step     (step),
        .op_div   (op_div),
        .a_in     (a_in),
        .b_in     (b_in),
        .work_nxt (work_nxt)
    );

    // Result write-back on the final iteration edge
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            a_out <= '0;
            b_out <= '0;
            cy    <= 1'b0;
            ov    <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                cy <= 1'b0;
                if (work_nxt.op == OP_MUL) begin
                    a_out <= work_nxt.lo;
                    b_out <= work_nxt.hi;
                    ov    <= |work_nxt.hi;
                end else if (work_nxt.dvs == '0) begin
                    a_out <= work_nxt.a0;
                    b_out <= work_nxt.b0;
                    ov    <= 1'b1;
                end else begin
                    a_out <= work_nxt.lo;
                    b_out <= work_nxt.hi;
                    ov    <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
    import mdu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             op_div,
    input logic [MDU_W-1:0] a_in,
    input logic [MDU_W-1:0] b_in,
    input logic             busy,
    input logic             done,
    input logic [MDU_W-1:0] a_out,
    input logic [MDU_W-1:0] b_out,
    input logic             cy,
    input logic             ov
);

    localparam logic [MDU_CW-1:0] RUN_LEN = MDU_CW'(MDU_W);
    localparam int unsigned       DW      = 2 * MDU_W;

    logic [MDU_W-1:0]  a_q, b_q;
    logic              div_q;
    logic [MDU_CW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            div_q <= 1'b0;
            cyc   <= '0;
        end else if (start && !busy) begin
            a_q   <= a_in;
            b_q   <= b_in;
            div_q <= op_div;
            cyc   <= '0;
        end else if (busy) begin
            cyc <= cyc + 1'b1;
        end
    end

    logic [DW-1:0] prod_w, recon_w;
    always_comb begin
        prod_w  = DW'(a_q) * DW'(b_q);
        recon_w = DW'(a_out) * DW'(b_q) + DW'(b_out);
    end

    // R2
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    // R3
    p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc == RUN_LEN) && !busy);
    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4
    p_mul_result_r4: assert property (@(posedge clk) disable iff (rst)
        done && !div_q |-> {b_out, a_out} == prod_w);
    // R5
    p_mul_cy_r5: assert property (@(posedge clk) disable iff (rst)
        done && !div_q |-> !cy);
    // R6
    p_mul_ov_r6: assert property (@(posedge clk) disable iff (rst)
        done && !div_q |-> ov == (prod_w > DW'(255)));
    // R7
    p_div_result_r7: assert property (@(posedge clk) disable iff (rst)
        done && div_q && (b_q != '0) |-> (recon_w == DW'(a_q)) && (b_out < b_q));
    // R8
    p_div_flags_r8: assert property (@(posedge clk) disable iff (rst)
        done && div_q && (b_q != '0) |-> !cy && !ov);
    // R9
    p_div_zero_r9: assert property (@(posedge clk) disable iff (rst)
        done && div_q && (b_q == '0) |-> ov && !cy && a_out == a_q && b_out == b_q);
    // R10
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        busy && (cyc != RUN_LEN - 1'b1) |=> busy);
    // R11
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(a_out) && $stable(b_out) && $stable(cy) && $stable(ov) || done);

endmodule

bind byte_muldiv mdu_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_div (op_div),
    .a_in   (a_in),
    .b_in   (b_in),
    .busy   (busy),
    .done   (done),
    .a_out  (a_out),
    .b_out  (b_out),
    .cy     (cy),
    .ov     (ov)
);

// File: tb/byte_muldiv_bench.sv
module byte_muldiv_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       op_div = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic       busy, done, cy, ov;
    logic [7:0] a_out, b_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 4 ns period

    byte_muldiv u_byte_muldiv (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div),
        .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
        .a_out(a_out), .b_out(b_out), .cy(cy), .ov(ov)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                report();
            end
        end
    end

    // One operation; optional extra start pulse while busy (R10)
    task automatic run_op(input bit op, input logic [7:0] a, input logic [7:0] b,
                          input bit disturb);
        logic [15:0] p;
        logic [7:0]  ea, eb, ha, hb;
        bit          eov;
        int          n;
        string       rq;
        if (!op) begin
            p = 16'(a) * 16'(b);
            ea = p[7:0]; eb = p[15:8]; eov = (p > 16'd255); rq = "R4";
        end else if (b == 0) begin
            ea = a; eb = b; eov = 1'b1; rq = "R9";
        end else begin
            ea = a / b; eb = a % b; eov = 1'b0; rq = "R7";
        end
        @(negedge clk);
        start = 1'b1; op_div = op; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0; op_div = ~op; a_in = ~a; b_in = b + 8'd3;
        chk(busy == 1'b1, "R2", busy, 1);
        ha = a_out; hb = b_out;
        n = 1;
        while (!done && n < 40) begin
            start = (disturb && n == 3);
            @(negedge clk);
            n++;
            if (!done) chk(a_out == ha && b_out == hb, "R11", {a_out, b_out}, {ha, hb});
        end
        start = 1'b0;
        chk(n == 9, disturb ? "R10" : "R3", n, 9);
        chk(!busy, "R3", busy, 0);
        chk(a_out == ea, disturb ? "R10" : rq, a_out, ea);
        chk(b_out == eb, rq, b_out, eb);
        chk(cy == 1'b0, op ? "R8" : "R5", cy, 0);
        chk(ov == eov, op ? (b == 0 ? "R9" : "R8") : "R6", ov, eov);
        @(negedge clk);
        chk(!done, "R3", done, 0);
        chk(a_out == ea && ov == eov, "R11", a_out, ea);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1", {busy, done}, 0);
        chk(a_out == 0 && b_out == 0, "R1", {a_out, b_out}, 0);
        chk(!cy && !ov, "R1", {cy, ov}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && a_out == 0, "R1", {busy, a_out}, 0);
    endtask

    task automatic t_multiply();
        run_op(1'b0, 8'd0,   8'd77,  1'b0);
        run_op(1'b0, 8'd15,  8'd17,  1'b0);   // 255: no overflow
        run_op(1'b0, 8'd16,  8'd16,  1'b0);   // 256: overflow
        run_op(1'b0, 8'd255, 8'd255, 1'b0);
        run_op(1'b0, 8'd200, 8'd1,   1'b0);
    endtask

    task automatic t_divide();
        run_op(1'b0, 8'd20,  8'd20,  1'b0);   // leave ov set first
        run_op(1'b1, 8'd200, 8'd7,   1'b0);
        run_op(1'b1, 8'd5,   8'd9,   1'b0);
        run_op(1'b1, 8'd255, 8'd1,   1'b0);
        run_op(1'b1, 8'd0,   8'd3,   1'b0);
        run_op(1'b1, 8'd255, 8'd255, 1'b0);
    endtask

    task automatic t_div_zero();
        run_op(1'b0, 8'd99,  8'd99,  1'b0);
        run_op(1'b1, 8'h5A,  8'd0,   1'b0);
        run_op(1'b1, 8'd100, 8'd10,  1'b0);   // ov must clear again
    endtask

    task automatic t_busy_start();
        run_op(1'b0, 8'd13,  8'd11,  1'b1);
        run_op(1'b1, 8'd250, 8'd16,  1'b1);
    endtask

    initial begin
        t_reset();
        t_multiply();
        t_divide();
        t_div_zero();
        t_busy_start();
        repeat (2) @(negedge clk);
        report();
    end

endmodule